// File: doc/BRIEF.md
# ARINC 429 Word Transmitter with Staging Queue

This block takes 32-bit words from a host over a 16-bit write path, holds them in a 32-entry queue and sends them one after another as a return-to-zero serial stream on a pair of digital line-drive outputs. Each word is written as two halves. The low half is captured first. Writing the high half completes the word and places it in the queue.

Once the transmit enable is high, the serializer takes the oldest word and sends it. Each bit is a data mark for half a bit time followed by a NULL for the other half. After bit 32 comes a gap of four bit times. A rate input sets the bit time to either 10 or 80 master clocks. Bit 32 can be sent as loaded, or it can be replaced by an odd or even parity bit computed over bits 1 to 31.

Flags report three conditions: the transmitter is idle and empty, the queue holds at least half its depth, and the queue is full. A test input holds the line outputs at NULL. A self-test path copies the serial stream onto two loopback output pairs, one straight and one inverted, for the receive side.

Top module: `a429_tx_top`

## Requirements
- R1: After a synchronous active-low reset, `tx_ready` is 1, `q_half` and `q_full` are 0, and all line and loopback outputs are 0.
- R2: A pulse on `wr_lo` captures `wr_data` as word bits 16..1. A following pulse on `wr_hi` appends `{wr_data, captured}` to the queue. Words are sent in load order, bit 1 (`word[0]`) first and bit 32 (`word[31]`) last. A ONE drives `line_a`=1 and `line_b`=0, a ZERO drives `line_a`=0 and `line_b`=1, and NULL drives both to 0. The two line outputs are never high together.
- R3: With `slow_rate`=0, each bit is 5 clocks of mark followed by 5 clocks of NULL. When another word is queued and enable is high, the gap between bit 32's NULL and the next word's first mark is exactly 40 clocks.
- R4: With `slow_rate`=1, each bit is 40 clocks of mark and 40 clocks of NULL, and the gap between queued words is 320 clocks. The rate is taken at the start of each word.
- R5: With `par_en`=1, bit 32 is replaced so that the ones count over bits 1..32 is odd when `par_even`=0 and even when `par_even`=1. With `par_en`=0, all 32 loaded bits are sent unchanged.
- R6: `q_half` is 1 exactly when the queue holds 16 or more words. `q_full` is 1 when it holds 32. A completing write while full is dropped, and that word is never sent.
- R7: `tx_ready` goes to 0 in the cycle after a word is accepted. It returns to 1 only when the queue is empty and the gap after the last word has ended. While `tx_ready` is 1, both line outputs are 0.
- R8: While `force_null`=1, `line_a` and `line_b` are both 0, whatever is being sent.
- R9: With `self_test`=1, `lb1_a`/`lb1_b` carry the serial stream as ONE/ZERO/NULL and are not affected by `force_null`. `lb2_a`/`lb2_b` carry the same stream inverted (`lb2_a`=`lb1_b`, `lb2_b`=`lb1_a`). With `self_test`=0, all four loopback outputs are 0.
- R10: If `tx_en` is 1 at a word boundary and the queue is not empty, the first mark appears on the line one clock later. If `tx_en` drops during a word, that word and its gap still complete, and no further word starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_lo | input | 1 | Capture low half of a word from wr_data |
| wr_hi | input | 1 | Take high half from wr_data and enqueue the word |
| wr_data | input | 16 | Host write data |
| tx_en | input | 1 | Allow words to start |
| slow_rate | input | 1 | 0: bit = 10 clocks, 1: bit = 80 clocks |
| par_en | input | 1 | Replace bit 32 with parity |
| par_even | input | 1 | 0: odd parity, 1: even parity |
| force_null | input | 1 | Hold line outputs at NULL |
| self_test | input | 1 | Enable loopback outputs |
| line_a | output | 1 | Line-drive output A |
| line_b | output | 1 | Line-drive output B |
| lb1_a | output | 1 | Loopback to receiver 1, A side |
| lb1_b | output | 1 | Loopback to receiver 1, B side |
| lb2_a | output | 1 | Loopback to receiver 2 (inverted), A side |
| lb2_b | output | 1 | Loopback to receiver 2 (inverted), B side |
| tx_ready | output | 1 | Queue empty and serializer idle |
| q_half | output | 1 | Queue holds 16 or more words |
| q_full | output | 1 | Queue holds 32 words |

## Verification
The hardest condition to reach is a write that arrives while the queue is full. To show that it was dropped, the bench loads all 32 entries with transmit disabled and then writes a 33rd, distinct word. It then enables transmit and decodes all 32 words from the line. The stream must match the first 32 loads in order and then fall idle with `tx_ready` high, with no trace of the extra word. Measuring the exact inter-word gap needs a second word already queued when the first ends, so both words are loaded before enabling.

// File: rtl/a429_tx_pkg.sv
// Shared types and helpers for the word transmitter.
// Assumes: word width of at least 2 bits; parity covers all bits except the last.
package a429_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MARK = 2'd1,
        ST_NULL = 2'd2,
        ST_GAP  = 2'd3
    } tx_state_e;

    // Parity bit that makes the whole word odd (even=0) or even (even=1).
    function automatic logic last_bit_parity(input logic [30:0] data, input logic even);
        return even ? (^data) : ~(^data);
    endfunction

endpackage

// File: rtl/a429_word_fifo.sv
// Word queue: circular buffer with occupancy count and half/full flags.
// Assumes: push while full is dropped; pop only acts when not empty.
module a429_word_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 32,
    parameter int HALF  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             empty,
    output logic             full,
    output logic             half
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             push_ok, pop_ok;

    assign push_ok  = push && !full;
    assign pop_ok   = pop && !empty;
    assign empty    = (count == '0);
    assign full     = (count == CW'(DEPTH));
    assign half     = (count >= CW'(HALF));
    assign pop_data = mem[rd_ptr];

    // Storage write on accepted push.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/a429_tx_serializer.sv
// Serializer: pulls words from the queue and sequences mark, NULL and gap.
// Assumes: rate and parity settings are taken when a word starts; a word
// in flight always completes with its gap even if enable drops.
module a429_tx_serializer
    import a429_tx_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80,
    parameter int GAP_BITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             slow_rate,
    input  logic             par_en,
    input  logic             par_even,
    input  logic             q_empty,
    input  logic [WIDTH-1:0] q_word,
    output logic             pop,
    output logic             busy,
    output logic             mark_valid,
    output logic             mark_bit
);
    localparam int CNT_W = $clog2(GAP_BITS * DIV_SLOW + 1);
    localparam int BIT_W = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] HL_FAST = CNT_W'(DIV_FAST / 2 - 1);
    localparam logic [CNT_W-1:0] HL_SLOW = CNT_W'(DIV_SLOW / 2 - 1);
    localparam logic [CNT_W-1:0] GL_FAST = CNT_W'(GAP_BITS * DIV_FAST - 1);
    localparam logic [CNT_W-1:0] GL_SLOW = CNT_W'(GAP_BITS * DIV_SLOW - 1);

    tx_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [BIT_W-1:0] bit_idx;
    logic [WIDTH-1:0] shreg;
    logic             slow_q;
    logic [CNT_W-1:0] half_last, gap_last;
    logic [WIDTH-1:0] framed;
    logic             start;

    assign half_last = slow_q ? HL_SLOW : HL_FAST;
    assign gap_last  = slow_q ? GL_SLOW : GL_FAST;

    // Word as it will go on the line, with optional parity in the last bit.
    always_comb begin
        framed = q_word;
        if (par_en) framed[WIDTH-1] = last_bit_parity(q_word[30:0], par_even);
    end

    // A word starts from idle, or straight at the end of a gap.
    assign start = enable && !q_empty &&
                   ((state == ST_IDLE) || (state == ST_GAP && cnt == gap_last));
    assign pop        = start;
    assign busy       = (state != ST_IDLE);
    assign mark_valid = (state == ST_MARK);
    assign mark_bit   = shreg[0];

    // Bit/phase sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            slow_q  <= 1'b0;
        end else if (start) begin
            state   <= ST_MARK;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= framed;
            slow_q  <= slow_rate;
        end else begin
            case (state)
                ST_MARK: begin
                    if (cnt == half_last) begin
                        state <= ST_NULL;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                ST_NULL: begin
                    if (cnt == half_last) begin
                        cnt <= '0;
                        if (bit_idx == BIT_W'(WIDTH - 1)) state <= ST_GAP;
                        else begin
                            state   <= ST_MARK;
                            bit_idx <= bit_idx + 1'b1;
                            shreg   <= shreg >> 1;
                        end
                    end else cnt <= cnt + 1'b1;
                end
                ST_GAP: begin
                    if (cnt == gap_last) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/a429_line_stage.sv
// Line stage: maps mark state to A/B levels, applies forced NULL and
// produces the straight and inverted loopback pairs.
// Assumes: loopback taps the stream ahead of the forced-NULL gate.
module a429_line_stage (
    input  logic mark_valid,
    input  logic mark_bit,
    input  logic force_null,
    input  logic self_test,
    output logic line_a,
    output logic line_b,
    output logic lb1_a,
    output logic lb1_b,
    output logic lb2_a,
    output logic lb2_b
);
    logic raw_a, raw_b;

    // Three-level encoding of the serial stream.
    always_comb begin
        raw_a = mark_valid &  mark_bit;
        raw_b = mark_valid & ~mark_bit;
    end

    // Line outputs held at NULL under test control.
    always_comb begin
        line_a = raw_a & ~force_null;
        line_b = raw_b & ~force_null;
    end

    // Loopback pairs: receiver 1 straight, receiver 2 inverted.
    always_comb begin
        lb1_a = raw_a & self_test;
        lb1_b = raw_b & self_test;
        lb2_a = raw_b & self_test;
        lb2_b = raw_a & self_test;
    end
endmodule

// File: rtl/a429_tx_top.sv
// Word transmitter top: half-word staging, queue, serializer and line stage.
// Assumes: host writes the low half before the high half of each word.
module a429_tx_top #(
    parameter int WIDTH    = 32,
    parameter int DEPTH    = 32,
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80,
    parameter int GAP_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_lo,
    input  logic                 wr_hi,
    input  logic [WIDTH/2-1:0]   wr_data,
    input  logic                 tx_en,
    input  logic                 slow_rate,
    input  logic                 par_en,
    input  logic                 par_even,
    input  logic                 force_null,
    input  logic                 self_test,
    output logic                 line_a,
    output logic                 line_b,
    output logic                 lb1_a,
    output logic                 lb1_b,
    output logic                 lb2_a,
    output logic                 lb2_b,
    output logic                 tx_ready,
    output logic                 q_half,
    output logic                 q_full
);
    localparam int HW = WIDTH / 2;

    logic [HW-1:0]    lo_hold;
    logic [WIDTH-1:0] q_word;
    logic             q_empty, pop, busy, mark_valid, mark_bit;

    // Low-half staging register.
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_hold <= '0;
        else if (wr_lo) lo_hold <= wr_data;
    end

    a429_word_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .HALF(DEPTH / 2)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_hi),
        .push_data ({wr_data, lo_hold}),
        .pop       (pop),
        .pop_data  (q_word),
        .empty     (q_empty),
        .full      (q_full),
        .half      (q_half)
    );

    a429_tx_serializer #(
        .WIDTH(WIDTH), .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW), .GAP_BITS(GAP_BITS)
    ) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (tx_en),
        .slow_rate  (slow_rate),
        .par_en     (par_en),
        .par_even   (par_even),
        .q_empty    (q_empty),
        .q_word     (q_word),
        .pop        (pop),
        .busy       (busy),
        .mark_valid (mark_valid),
        .mark_bit   (mark_bit)
    );

    a429_line_stage u_line (
        .mark_valid (mark_valid),
        .mark_bit   (mark_bit),
        .force_null (force_null),
        .self_test  (self_test),
        .line_a     (line_a),
        .line_b     (line_b),
        .lb1_a      (lb1_a),
        .lb1_b      (lb1_b),
        .lb2_a      (lb2_a),
        .lb2_b      (lb2_b)
    );

    // Ready when nothing is queued and nothing is on the wire.
    assign tx_ready = q_empty && !busy;
endmodule

// File: rtl/a429_tx_chk.sv
// Property checker for the word transmitter, bound to the top module.
module a429_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_hi,
    input logic force_null,
    input logic self_test,
    input logic line_a,
    input logic line_b,
    input logic lb1_a,
    input logic lb1_b,
    input logic lb2_a,
    input logic lb2_b,
    input logic tx_ready,
    input logic q_half,
    input logic q_full
);
    AST_LINE_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n) !(line_a && line_b)); // R2
    AST_FULL_IMPLIES_HALF: assert property (@(posedge clk) disable iff (!rst_n) q_full |-> q_half); // R6
    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (wr_hi && !q_full) |=> !tx_ready); // R7
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n) tx_ready |-> (!line_a && !line_b)); // R7
    AST_FORCED_NULL: assert property (@(posedge clk) disable iff (!rst_n) force_null |-> (!line_a && !line_b)); // R8
    AST_LOOP_INVERTED: assert property (@(posedge clk) disable iff (!rst_n) (lb2_a == lb1_b) && (lb2_b == lb1_a)); // R9
    AST_LOOP_OFF: assert property (@(posedge clk) disable iff (!rst_n) !self_test |-> !(lb1_a || lb1_b || lb2_a || lb2_b)); // R9
endmodule

bind a429_tx_top a429_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hi      (wr_hi),
    .force_null (force_null),
    .self_test  (self_test),
    .line_a     (line_a),
    .line_b     (line_b),
    .lb1_a      (lb1_a),
    .lb1_b      (lb1_b),
    .lb2_a      (lb2_a),
    .lb2_b      (lb2_b),
    .tx_ready   (tx_ready),
    .q_half     (q_half),
    .q_full     (q_full)
);

// File: tb/a429_tx_top_bench.sv
module a429_tx_top_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_lo = 1'b0, wr_hi = 1'b0;
    logic [15:0] wr_data = '0;
    logic tx_en = 1'b0, slow_rate = 1'b0, par_en = 1'b0, par_even = 1'b0;
    logic force_null = 1'b0, self_test = 1'b0;
    logic line_a, line_b, lb1_a, lb1_b, lb2_a, lb2_b, tx_ready, q_half, q_full;
    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    a429_tx_top u_a429_tx_top (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .tx_en(tx_en), .slow_rate(slow_rate), .par_en(par_en), .par_even(par_even),
        .force_null(force_null), .self_test(self_test),
        .line_a(line_a), .line_b(line_b), .lb1_a(lb1_a), .lb1_b(lb1_b),
        .lb2_a(lb2_a), .lb2_b(lb2_b), .tx_ready(tx_ready), .q_half(q_half), .q_full(q_full)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_word(input logic [31:0] w);
        @(negedge clk); wr_lo = 1'b1; wr_data = w[15:0];
        @(negedge clk); wr_lo = 1'b0; wr_hi = 1'b1; wr_data = w[31:16];
        @(negedge clk); wr_hi = 1'b0;
    endtask

    task automatic wait_ready();
        int k = 0;
        while (!tx_ready && k < 20000) begin @(negedge clk); k++; end
    endtask

    // Decode one word from the line; returns latency to first mark and null run after it.
    task automatic capture(input int half, input int gap_lim, output logic [31:0] w,
                           output int lat, output int gap, output bit shape_ok);
        lat = 0;
        while (!(line_a || line_b) && lat < 2000) begin @(negedge clk); lat++; end
        shape_ok = 1'b1;
        w = '0;
        for (int i = 0; i < 32; i++) begin
            w[i] = line_a;
            if (line_a == line_b) shape_ok = 1'b0;
            repeat (half) @(negedge clk);
            if (line_a || line_b) shape_ok = 1'b0;
            repeat (half) @(negedge clk);
        end
        gap = 0;
        while (!(line_a || line_b) && gap < gap_lim) begin gap++; @(negedge clk); end
    endtask

    task automatic t_reset();
        chk(tx_ready == 1'b1, "R1 ready", {31'd0, tx_ready}, 32'd1);
        chk(!q_half && !q_full, "R1 flags", {30'd0, q_half, q_full}, 32'd0);
        chk(!(line_a || line_b || lb1_a || lb1_b || lb2_a || lb2_b), "R1 outputs",
            {26'd0, line_a, line_b, lb1_a, lb1_b, lb2_a, lb2_b}, 32'd0);
    endtask

    task automatic t_basic();
        logic [31:0] w; int lat, gap; bit ok;
        slow_rate = 1'b0; par_en = 1'b0;
        load_word(32'hA5C3_0F81);
        chk(tx_ready == 1'b0, "R7 ready low after load", {31'd0, tx_ready}, 32'd0);
        load_word(32'h8000_0001);
        @(negedge clk); tx_en = 1'b1;
        capture(5, 2000, w, lat, gap, ok);
        chk(lat == 1, "R10 start latency", lat, 1);
        chk(w == 32'hA5C3_0F81, "R2 first word", w, 32'hA5C3_0F81);
        chk(ok, "R2 R3 bit shape fast", {31'd0, ok}, 32'd1);
        chk(gap == 40, "R3 word gap fast", gap, 40);
        capture(5, 300, w, lat, gap, ok);
        chk(w == 32'h8000_0001, "R2 second word order", w, 32'h8000_0001);
        chk(tx_ready == 1'b1, "R7 ready after last gap", {31'd0, tx_ready}, 32'd1);
        tx_en = 1'b0;
    endtask

    task automatic t_slow();
        logic [31:0] w; int lat, gap; bit ok;
        slow_rate = 1'b1;
        load_word(32'h1234_5678);
        load_word(32'hFEDC_BA98);
        @(negedge clk); tx_en = 1'b1;
        capture(40, 2000, w, lat, gap, ok);
        chk(w == 32'h1234_5678 && ok, "R4 slow word", w, 32'h1234_5678);
        chk(gap == 320, "R4 word gap slow", gap, 320);
        capture(40, 400, w, lat, gap, ok);
        chk(w == 32'hFEDC_BA98 && ok, "R4 slow second word", w, 32'hFEDC_BA98);
        tx_en = 1'b0; slow_rate = 1'b0;
        wait_ready();
    endtask

    task automatic t_parity();
        logic [31:0] w; int lat, gap; bit ok;
        par_en = 1'b1; par_even = 1'b0;
        load_word(32'h8000_0007);
        @(negedge clk); tx_en = 1'b1;
        capture(5, 100, w, lat, gap, ok);
        chk(w == 32'h0000_0007, "R5 odd parity", w, 32'h0000_0007);
        tx_en = 1'b0; wait_ready();
        par_even = 1'b1;
        load_word(32'h0000_0007);
        @(negedge clk); tx_en = 1'b1;
        capture(5, 100, w, lat, gap, ok);
        chk(w == 32'h8000_0007, "R5 even parity", w, 32'h8000_0007);
        tx_en = 1'b0; wait_ready();
        par_en = 1'b0;
        load_word(32'h0000_0007);
        @(negedge clk); tx_en = 1'b1;
        capture(5, 100, w, lat, gap, ok);
        chk(w == 32'h0000_0007, "R5 parity off keeps data", w, 32'h0000_0007);
        tx_en = 1'b0; wait_ready();
    endtask

    task automatic t_fill();
        logic [31:0] w; int lat, gap; bit ok; int bad = 0;
        for (int i = 0; i < 15; i++) load_word(32'h1000_0000 + i * 32'h0101_0101);
        chk(q_half == 1'b0, "R6 half clear at 15", {31'd0, q_half}, 32'd0);
        load_word(32'h1000_0000 + 15 * 32'h0101_0101);
        chk(q_half == 1'b1, "R6 half set at 16", {31'd0, q_half}, 32'd1);
        for (int i = 16; i < 32; i++) load_word(32'h1000_0000 + i * 32'h0101_0101);
        chk(q_full == 1'b1, "R6 full at 32", {31'd0, q_full}, 32'd1);
        load_word(32'hDEAD_BEEF);
        chk(q_full == 1'b1, "R6 full after extra", {31'd0, q_full}, 32'd1);
        @(negedge clk); tx_en = 1'b1;
        for (int i = 0; i < 32; i++) begin
            capture(5, 300, w, lat, gap, ok);
            if (w != 32'h1000_0000 + i * 32'h0101_0101) begin
                bad++;
                chk(1'b0, "R6 drain order", w, 32'h1000_0000 + i * 32'h0101_0101);
            end
        end
        chk(bad == 0, "R6 all 32 words sent", bad, 0);
        chk(gap == 300 && tx_ready, "R6 extra word dropped", gap, 300);
        tx_en = 1'b0;
    endtask

    task automatic t_disable();
        logic [31:0] w; int lat, gap; bit ok;
        load_word(32'h0F0F_3C3C);
        load_word(32'h5555_AAAA);
        @(negedge clk); tx_en = 1'b1;
        @(negedge clk); tx_en = 1'b0;
        capture(5, 200, w, lat, gap, ok);
        chk(w == 32'h0F0F_3C3C && ok, "R10 word completes after disable", w, 32'h0F0F_3C3C);
        chk(gap == 200, "R10 no new word while disabled", gap, 200);
        chk(tx_ready == 1'b0, "R7 ready low with word queued", {31'd0, tx_ready}, 32'd0);
        @(negedge clk); tx_en = 1'b1;
        capture(5, 100, w, lat, gap, ok);
        chk(w == 32'h5555_AAAA, "R10 resumes on enable", w, 32'h5555_AAAA);
        tx_en = 1'b0; wait_ready();
    endtask

    task automatic t_force_loop();
        int line_on = 0, lb_on = 0, swap_bad = 0, lb_off_bad = 0;
        load_word(32'hFFFF_0000);
        self_test = 1'b1;
        @(negedge clk); tx_en = 1'b1;
        @(negedge clk); force_null = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (line_a || line_b) line_on++;
            if (lb1_a || lb1_b) lb_on++;
            if (lb2_a != lb1_b || lb2_b != lb1_a) swap_bad++;
        end
        chk(line_on == 0, "R8 forced null", line_on, 0);
        chk(lb_on > 0, "R9 loopback active under force", lb_on, 1);
        chk(swap_bad == 0, "R9 receiver 2 inverted", swap_bad, 0);
        force_null = 1'b0; self_test = 1'b0;
        line_on = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (line_a || line_b) line_on++;
            if (lb1_a || lb1_b || lb2_a || lb2_b) lb_off_bad++;
        end
        chk(line_on > 0, "R8 line resumes after release", line_on, 1);
        chk(lb_off_bad == 0, "R9 loopback off", lb_off_bad, 0);
        tx_en = 1'b0; wait_ready();
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_slow();
        t_parity();
        t_fill();
        t_disable();
        t_force_loop();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule